// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

The walker feeds a transmit stream from frames described in memory. Software builds a chain of 8-byte descriptors. Each descriptor is a 32-bit control word followed by a 32-bit pointer word. Software then sets a start-request bit. The walker enters the chain through its queue's entry in a descriptor base-address table, which is a link descriptor. It fetches each descriptor and decodes its 4-bit type code. Single-frame descriptors have their payload read from memory and sent out byte by byte on a valid/ready stream. Link descriptors move the fetch pointer to a new address. Any other type ends the walk.

When a frame has been sent, the walker writes its control word back with the type changed to "empty". Software polls that field to learn the frame is done. When the walk ends, the walker clears the start-request bit, so software can also poll that bit to see that the whole chain has been consumed. Memory is a single 32-bit word port. A read issued in one cycle returns its data on `mem_rdata` in the next cycle.

Top module: `txdesc_walker`

## Requirements
- R1: During and after reset, `ctrl_rdata` reads 0, `out_valid` is low, and no memory read or write is issued until the start bit is set.
- R2: A control write with `ctrl_wdata_start` = 1 sets bit 0 of `ctrl_rdata`. The walker's first memory read after that is the control word at `tbl_base + 8*QUEUE_IDX`.
- R3: A descriptor whose control bits 31:28 equal 0x9 (link) makes the next fetch come from the address in its pointer word. No bytes are emitted for it and it is never written.
- R4: For a descriptor of type 0x7 (single frame), the walker emits the bytes at addresses ptr .. ptr+len-1 in increasing order, where len is control bits 11:0. The byte at address a is taken from bits 8*(a mod 4)+7 : 8*(a mod 4) of the memory word.
- R5: `out_last` is high on the final byte of each frame and on no other byte. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.
- R6: After its last byte, a frame's control word is written back with bits 31:28 = 0x3 and bits 27:0 unchanged. Its pointer word is not touched, and the next descriptor is fetched from the descriptor address + 8.
- R7: A frame of length 0 emits no bytes and is still written back as in R6.
- R8: A descriptor of any type other than 0x7 or 0x9 (for example 0x3 empty, 0xA end-of-set or 0xC) ends the walk. It is not written, and bit 0 of `ctrl_rdata` returns to 0.
- R9: A control write with `ctrl_wdata_start` = 0 has no effect. A write of 1 while a walk is in progress neither restarts nor disturbs it.
- R10: A payload pointer need not be word aligned, and payloads may span word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | AW | Byte address of the descriptor base-address table |
| ctrl_wr_en | input | 1 | Host write strobe for the transmit control register |
| ctrl_wdata_start | input | 1 | Host write data for the start-request bit |
| ctrl_rdata | output | 32 | Transmit control register; bit 0 is the start-request bit |
| mem_rd_en | output | 1 | Memory word read request |
| mem_wr_en | output | 1 | Memory word write request |
| mem_addr | output | AW | Byte address of the memory access (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the current frame |

## Verification
The assertions assume a memory that returns read data exactly one cycle after a request. They also assume the chain written by software is well formed: link pointers and descriptor addresses are multiples of 8, and every link eventually leads to a terminating descriptor. The bench's memory model has that fixed latency, and every chain it builds is acyclic and ends in an empty, end-of-set or unknown type. The consumer's `out_ready` is driven freely, either always high, alternating or pseudo-random, because the walker places no constraint on it.

// File: rtl/txw_pkg.sv
package txw_pkg;

  typedef enum logic [1:0] {
    K_FRAME = 2'd0,
    K_LINK  = 2'd1,
    K_STOP  = 2'd2
  } kind_e;

  localparam logic [3:0] T_FRAME = 4'h7;
  localparam logic [3:0] T_LINK  = 4'h9;
  localparam logic [3:0] T_DONE  = 4'h3;

  // Type code in the top nibble of the control word
  function automatic kind_e classify(input logic [31:0] c);
    kind_e k;
    case (c[31:28])
      T_FRAME: k = K_FRAME;
      T_LINK:  k = K_LINK;
      default: k = K_STOP;
    endcase
    return k;
  endfunction

  // Completion value: type becomes empty, everything else preserved
  function automatic logic [31:0] retire(input logic [31:0] c);
    return {T_DONE, c[27:0]};
  endfunction

  // Little-endian byte lane selection
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/txw_start_reg.sv
module txw_start_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we_i,
  input  logic        host_bit_i,
  input  logic        clear_i,
  output logic        start_o,
  output logic [31:0] rdata_o
);
  logic start_q;

  // A host set wins over a same-cycle clear so no request is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     start_q <= 1'b0;
    else if (host_we_i && host_bit_i) start_q <= 1'b1;
    else if (clear_i)               start_q <= 1'b0;
  end

  assign start_o = start_q;
  assign rdata_o = {31'b0, start_q};
endmodule

// File: rtl/txw_decode.sv
module txw_decode #(
  parameter int LEN_W = 12
) (
  input  logic [31:0]      ctrl_i,
  output txw_pkg::kind_e   kind_o,
  output logic [LEN_W-1:0] len_o,
  output logic             zero_len_o
);
  assign kind_o     = txw_pkg::classify(ctrl_i);
  assign len_o      = ctrl_i[LEN_W-1:0];
  assign zero_len_o = (ctrl_i[LEN_W-1:0] == '0);
endmodule

// File: rtl/txw_payload.sv
module txw_payload #(
  parameter int AW    = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             word_we_i,
  input  logic [31:0]      word_i,
  input  logic             adv_i,
  output logic [AW-1:0]    word_addr_o,
  output logic [7:0]       byte_o,
  output logic             last_o,
  output logic             wrap_o
);
  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [31:0]      buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= ptr_i;
      rem_q  <= len_i;
    end else if (adv_i) begin
      addr_q <= addr_q + AW'(1);
      rem_q  <= rem_q - ONE_LEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         buf_q <= '0;
    else if (word_we_i) buf_q <= word_i;
  end

  assign word_addr_o = {addr_q[AW-1:2], 2'b00};
  assign byte_o      = txw_pkg::pick_byte(buf_q, addr_q[1:0]);
  assign last_o      = (rem_q == ONE_LEN);
  assign wrap_o      = (addr_q[1:0] == 2'b11);
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker #(
  parameter int AW          = 16,
  parameter int LEN_W       = 12,
  parameter int TBL_ENTRIES = 16,
  parameter int QUEUE_IDX   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base,
  input  logic          ctrl_wr_en,
  input  logic          ctrl_wdata_start,
  output logic [31:0]   ctrl_rdata,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  import txw_pkg::*;

  localparam int            DESC_BYTES = 8;
  localparam int            Q_EFF      = QUEUE_IDX % TBL_ENTRIES;
  localparam logic [AW-1:0] ENTRY_OFS  = AW'(Q_EFF * DESC_BYTES);
  localparam logic [AW-1:0] PTR_OFS    = AW'(DESC_BYTES / 2);
  localparam logic [AW-1:0] STEP       = AW'(DESC_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL_RQ, S_PTR_RQ, S_DECODE, S_DATA_RQ, S_DATA_WT, S_STREAM, S_WB
  } state_e;

  state_e        state_q;
  logic [AW-1:0] desc_q;
  logic [31:0]   ctrl_q;

  // Named events for the checker
  logic walker_busy, stop_evt, link_evt, frame_evt, empty_frame_evt;
  logic start_bit;

  kind_e            kind;
  logic [LEN_W-1:0] len;
  logic             zero_len;

  logic          pay_load, word_we, adv;
  logic [AW-1:0] word_addr;
  logic [7:0]    pay_byte;
  logic          pay_last, pay_wrap;

  txw_start_reg u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we_i  (ctrl_wr_en),
    .host_bit_i (ctrl_wdata_start),
    .clear_i    (stop_evt),
    .start_o    (start_bit),
    .rdata_o    (ctrl_rdata)
  );

  txw_decode #(.LEN_W(LEN_W)) u_dec (
    .ctrl_i     (ctrl_q),
    .kind_o     (kind),
    .len_o      (len),
    .zero_len_o (zero_len)
  );

  txw_payload #(.AW(AW), .LEN_W(LEN_W)) u_pay (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (pay_load),
    .ptr_i       (mem_rdata[AW-1:0]),
    .len_i       (len),
    .word_we_i   (word_we),
    .word_i      (mem_rdata),
    .adv_i       (adv),
    .word_addr_o (word_addr),
    .byte_o      (pay_byte),
    .last_o      (pay_last),
    .wrap_o      (pay_wrap)
  );

  assign walker_busy     = (state_q != S_IDLE);
  assign link_evt        = (state_q == S_DECODE) && (kind == K_LINK);
  assign stop_evt        = (state_q == S_DECODE) && (kind == K_STOP);
  assign frame_evt       = (state_q == S_DECODE) && (kind == K_FRAME);
  assign empty_frame_evt = frame_evt && zero_len;
  assign pay_load        = frame_evt && !zero_len;
  assign word_we         = (state_q == S_DATA_WT);

  assign out_valid = (state_q == S_STREAM);
  assign out_data  = pay_byte;
  assign out_last  = out_valid && pay_last;
  assign adv       = out_valid && out_ready;

  assign mem_rd_en = (state_q == S_CTRL_RQ) || (state_q == S_PTR_RQ) ||
                     (state_q == S_DATA_RQ);
  assign mem_wr_en = (state_q == S_WB);
  assign mem_wdata = retire(ctrl_q);

  always_comb begin
    case (state_q)
      S_PTR_RQ:  mem_addr = desc_q + PTR_OFS;
      S_DATA_RQ: mem_addr = word_addr;
      default:   mem_addr = desc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_bit) begin
          desc_q  <= tbl_base + ENTRY_OFS;
          state_q <= S_CTRL_RQ;
        end
        S_CTRL_RQ: state_q <= S_PTR_RQ;
        S_PTR_RQ: begin
          ctrl_q  <= mem_rdata;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          case (kind)
            K_LINK: begin
              desc_q  <= mem_rdata[AW-1:0];
              state_q <= S_CTRL_RQ;
            end
            K_FRAME: state_q <= zero_len ? S_WB : S_DATA_RQ;
            default: state_q <= S_IDLE;
          endcase
        end
        S_DATA_RQ: state_q <= S_DATA_WT;
        S_DATA_WT: state_q <= S_STREAM;
        S_STREAM: if (out_ready) begin
          if (pay_last)      state_q <= S_WB;
          else if (pay_wrap) state_q <= S_DATA_RQ;
        end
        S_WB: begin
          desc_q  <= desc_q + STEP;
          state_q <= S_CTRL_RQ;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_walker_chk.sv
module txdesc_walker_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr_en,
  input logic          ctrl_wdata_start,
  input logic [31:0]   ctrl_rdata,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [31:0]   mem_rdata,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          walker_busy,
  input logic          stop_evt,
  input logic          link_evt
);
  // R1: an idle walker is silent on memory and stream
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !walker_busy |-> (!mem_rd_en && !mem_wr_en && !out_valid));

  // R3: a link redirects the very next fetch to its pointer
  p_link_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (mem_rd_en && !mem_wr_en && mem_addr == $past(mem_rdata[AW-1:0])));

  // R5: last only accompanies a valid byte
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R5: stalled byte is held
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R6: write-back carries the empty type
  p_wb_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wdata[31:28] == 4'h3));

  // R6: after a write-back the next control word 8 bytes on is read
  p_wb_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (mem_rd_en && mem_addr == $past(mem_addr) + AW'(8)));

  // R6: one memory operation per cycle
  p_rdwr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R8: terminating descriptor drops the start bit
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !(ctrl_wr_en && ctrl_wdata_start)) |=> (ctrl_rdata[0] == 1'b0));
endmodule

bind txdesc_walker txdesc_walker_chk #(.AW(AW)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .ctrl_wr_en       (ctrl_wr_en),
  .ctrl_wdata_start (ctrl_wdata_start),
  .ctrl_rdata       (ctrl_rdata),
  .mem_rd_en        (mem_rd_en),
  .mem_wr_en        (mem_wr_en),
  .mem_addr         (mem_addr),
  .mem_wdata        (mem_wdata),
  .mem_rdata        (mem_rdata),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_data         (out_data),
  .out_last         (out_last),
  .walker_busy      (walker_busy),
  .stop_evt         (stop_evt),
  .link_evt         (link_evt)
);

// File: tb/txdesc_walker_tb_top.sv
`timescale 1ns/1ps
module txdesc_walker_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] tbl_base = 16'h0000;
  logic          ctrl_wr_en = 1'b0;
  logic          ctrl_wdata_start = 1'b0;
  logic [31:0]   ctrl_rdata;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          out_valid, out_last;
  logic          out_ready = 1'b1;
  logic [7:0]    out_data;

  always #10 clk = ~clk;

  txdesc_walker #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wdata_start(ctrl_wdata_start), .ctrl_rdata(ctrl_rdata),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  // Memory model with one-cycle read latency and a bench poke port
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [15:0] tb_wa = '0;
  logic [31:0] tb_wd = '0;
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr_en) mem[mem_addr[11:2]] <= mem_wdata;
    if (tb_we)     mem[tb_wa[11:2]] <= tb_wd;
  end

  int n_checks = 0;
  int n_fail = 0;
  int act_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_up();
  end

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = 16'(a); tb_wd = d;
    @(posedge clk);
    #1 tb_we = 1'b0;
  endtask

  task automatic host_write(input logic v);
    @(posedge clk); #2;
    ctrl_wr_en = 1'b1; ctrl_wdata_start = v;
    @(posedge clk); #2;
    ctrl_wr_en = 1'b0; ctrl_wdata_start = 1'b0;
  endtask

  // Ready patterns: 0 always, 1 alternate, 2 pseudo-random
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          rcyc = 0;
  initial forever begin
    @(posedge clk); #2;
    rcyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      1:       out_ready = rcyc[0];
      2:       out_ready = lfsr[0] | lfsr[5];
      default: out_ready = 1'b1;
    endcase
  end

  // Reference model: walk the memory image behaviourally
  logic [8:0]  exp_q[$];
  logic [47:0] wb_q[$];

  task automatic build_expect();
    int a;
    a = int'(tbl_base);
    exp_q.delete(); wb_q.delete();
    for (int step = 0; step < 64; step++) begin
      logic [31:0] c, p;
      c = mem[a / 4];
      p = mem[a / 4 + 1];
      if (c[31:28] == 4'h9) begin
        a = int'(p[15:0]);
      end else if (c[31:28] == 4'h7) begin
        int len;
        len = int'(c[11:0]);
        for (int i = 0; i < len; i++) begin
          int b;
          logic [31:0] w;
          b = int'(p[15:0]) + i;
          w = mem[b / 4];
          exp_q.push_back({(i == len - 1), 8'(w >> (8 * (b % 4)))});
        end
        wb_q.push_back({16'(a), 4'h3, c[27:0]});
        a = a + 8;
      end else begin
        break;
      end
    end
  endtask

  // Monitor, sampled between edges
  bit         mon_en = 1'b0;
  bit         first_rd_pend = 1'b0;
  bit         hold_pend = 1'b0;
  logic [7:0] hold_data;
  logic       hold_last;
  always @(negedge clk) begin
    if (mem_rd_en || mem_wr_en || out_valid) act_cnt++;
    if (mon_en) begin
      if (hold_pend)
        chk(out_valid && out_data == hold_data && out_last == hold_last, "R5",
            "stalled byte held", {out_valid, out_data, out_last}, {1'b1, hold_data, hold_last});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", out_data, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R4", "byte value", out_data, e[7:0]);
          chk(out_last == e[8], "R5", "last flag", out_last, e[8]);
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      hold_last = out_last;
      if (mem_wr_en) begin
        if (wb_q.size() == 0) chk(0, "R8", "unexpected write", mem_addr, 0);
        else begin
          logic [47:0] e;
          e = wb_q.pop_front();
          chk({mem_addr, mem_wdata} == e, "R6", "write-back", {mem_addr, mem_wdata}, e);
        end
      end
      if (mem_rd_en && first_rd_pend) begin
        chk(mem_addr == tbl_base, "R2", "first fetch address", mem_addr, tbl_base);
        first_rd_pend = 1'b0;
      end
    end
  end

  task automatic run_walk(input int mode, input bit mid_write);
    bit done;
    rdy_mode = mode;
    build_expect();
    first_rd_pend = 1'b1;
    mon_en = 1'b1;
    host_write(1'b1);
    @(negedge clk);
    chk(ctrl_rdata[0] == 1'b1, "R2", "start bit set", ctrl_rdata, 1);
    if (mid_write) begin
      repeat (10) @(negedge clk);
      host_write(1'b1);
    end
    done = 1'b0;
    for (int i = 0; i < 20000 && !done; i++) begin
      @(negedge clk);
      if (ctrl_rdata[0] == 1'b0) done = 1'b1;
    end
    chk(done, "R8", "walk ended and start bit cleared", done, 1);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all expected bytes seen", exp_q.size(), 0);
    chk(wb_q.size() == 0, "R6", "all write-backs seen", wb_q.size(), 0);
    mon_en = 1'b0;
  endtask

  task automatic chain_a();
    poke(16'h000, 32'h9000_0000); poke(16'h004, 32'h0000_0100);
    poke(16'h100, 32'h7000_0005); poke(16'h104, 32'h0000_0400);
    poke(16'h108, 32'h7000_0000); poke(16'h10C, 32'h0000_0480);
    poke(16'h110, 32'h7123_4007); poke(16'h114, 32'h0000_0503);
    poke(16'h118, 32'h9000_0000); poke(16'h11C, 32'h0000_0200);
    poke(16'h200, 32'h7000_0004); poke(16'h204, 32'h0000_0600);
    poke(16'h208, 32'hA000_0000); poke(16'h20C, 32'h0000_0000);
  endtask

  initial begin
    for (int w = 16'h400; w < 16'h700; w += 4)
      poke(w, 32'(w) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F);
    for (int e = 1; e < 16; e++) poke(e * 8, 32'hA000_0000);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ctrl_rdata == 32'h0 && !out_valid && !mem_rd_en && !mem_wr_en, "R1",
          "quiet in reset", {ctrl_rdata, out_valid, mem_rd_en, mem_wr_en}, 0);
    end
    rst_n = 1'b1;
    act_cnt = 0;
    repeat (5) @(negedge clk);
    chk(act_cnt == 0 && ctrl_rdata == 0, "R1", "quiet after reset", act_cnt, 0);

    // R9: writing zero does nothing
    host_write(1'b0);
    repeat (20) @(negedge clk);
    chk(ctrl_rdata == 0, "R9", "zero write leaves bit clear", ctrl_rdata, 0);
    chk(act_cnt == 0, "R9", "zero write starts nothing", act_cnt, 0);

    // Main chain: links, zero length, unaligned, end-of-set
    chain_a();
    run_walk(0, 1'b0);
    chk(mem[16'h118 / 4] == 32'h9000_0000, "R3", "link not written", mem[16'h118 / 4], 32'h9000_0000);
    chk(mem[16'h000 / 4] == 32'h9000_0000, "R3", "table link not written", mem[0], 32'h9000_0000);
    chk(mem[16'h104 / 4] == 32'h0000_0400, "R6", "pointer untouched", mem[16'h104 / 4], 32'h400);
    chk(mem[16'h108 / 4] == 32'h3000_0000, "R7", "empty frame retired", mem[16'h108 / 4], 32'h3000_0000);
    chk(mem[16'h110 / 4] == 32'h3123_4007, "R10", "unaligned frame retired", mem[16'h110 / 4], 32'h3123_4007);
    chk(mem[16'h208 / 4] == 32'hA000_0000, "R8", "end-of-set not written", mem[16'h208 / 4], 32'hA000_0000);

    // Same chain, pseudo-random ready
    chain_a();
    run_walk(2, 1'b0);

    // Second chain ending on empty type, alternate ready, re-request while busy
    poke(16'h004, 32'h0000_0300);
    poke(16'h300, 32'h7000_000B); poke(16'h304, 32'h0000_0401);
    poke(16'h308, 32'h7000_0001); poke(16'h30C, 32'h0000_06FF);
    poke(16'h310, 32'h3000_0000); poke(16'h314, 32'h0000_0000);
    run_walk(1, 1'b1);
    chk(mem[16'h310 / 4] == 32'h3000_0000, "R9", "walk ran to its end", mem[16'h310 / 4], 32'h3000_0000);

    // Unknown type ends the walk at once
    poke(16'h004, 32'h0000_0380);
    poke(16'h380, 32'hC000_0010); poke(16'h384, 32'h0000_0400);
    run_walk(0, 1'b0);
    chk(mem[16'h380 / 4] == 32'hC000_0010, "R8", "unknown type not written", mem[16'h380 / 4], 32'hC000_0010);

    // Table entry itself terminates
    poke(16'h000, 32'hA000_0000);
    act_cnt = 0;
    run_walk(2, 1'b0);
    chk(mem[0] == 32'hA000_0000, "R8", "table stop not written", mem[0], 32'hA000_0000);

    finish_up();
  end
endmodule